// File: doc/BRIEF.md
# Motor PWM Interrupt Status Unit

This block holds the interrupt flags and the status word of a three-phase motor PWM timer. The counter, the compare logic and the ADC converter sit outside it. They reach this block only as single-cycle event pulses and as a count-direction level. Each pulse sets a sticky flag. Software reads the flags over a small register bus and clears them by writing ones. One interrupt request line is raised while any flag is set whose enable bit is also set.

The six low flags each serve two event sources. For each channel, a mode input selects the source. With the channel's ADC-trigger mode off, the duty-compare match of that output sets the flag. With the mode on, the ADC-trigger counter match sets it instead, and the duty match is ignored. The enable bits for these six flags follow the same channel assignment.

An interval mode divides down the period interrupt. A 3-bit counter counts period matches and is visible in the status word. The period flag is raised only on the match at which that counter equals a programmed value. On that match the counter returns to zero.

Top module: `mpwm_irq_status`

## Requirements
- R1: After reset, every flag, the enable register, the control register and the interval counter are 0, and `irq` is 0.
- R2: Status bit 15 always shows `cnt_down` (0 = up, 1 = down). Writes to status bits 15 and 14:12 have no effect. Bits 11:8 of the status word always read 0.
- R3: With interval mode off, a `prd_match` pulse sets status bit 7 and a `bot_match` pulse sets status bit 6.
- R4: Writing the status word (address 0) clears each flag whose write-data bit is 1. A 0 bit leaves its flag unchanged.
- R5: When a flag is set by hardware and cleared by a write in the same cycle, the flag ends up set.
- R6: Status bit k (k = 0..5; bit 0 = UL, 1 = VL, 2 = WL, 3 = UH, 4 = VH, 5 = WH, and bit k is ADC channel k+1) is set by `duty_match[k]` when `atr_mode[k]` is 0 and by `atr_match[k]` when `atr_mode[k]` is 1. The source that is not selected is ignored.
- R7: With interval mode on and interval value V, each `prd_match` increments the counter in status bits 14:12. The match at which the counter already equals V instead sets bit 7 and resets the counter to 0. The period flag is therefore set once every V+1 matches.
- R8: The enable register sits at address 1, bits 7:0, each bit matching the status flag at the same position. Bits 15:8 read as 0. `irq` is 1 exactly when some flag and its enable bit are both 1.
- R9: The control register sits at address 2: bit 0 enables interval mode and bits 3:1 hold V. It reads back as written in those bits, and 0 elsewhere. Every write to it resets the interval counter to 0. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_down | input | 1 | Count direction of the PWM counter, 1 = down |
| prd_match | input | 1 | Period-match event pulse |
| bot_match | input | 1 | Bottom-match event pulse |
| duty_match | input | 6 | Per-output duty-match pulses, bit order as in R6 |
| atr_match | input | 6 | Per-channel ADC-trigger counter match pulses |
| atr_mode | input | 6 | Per-channel ADC-trigger mode select |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every event input is a clean, synchronous pulse of one cycle. They also assume that `atr_mode` changes only between events, so each flag always has exactly one selected source. The stimulus drives every input half a cycle away from the active edge and raises each pulse for a single cycle. It changes `atr_mode` only while all event inputs are low. The interval-counter bound relies on a control write always resetting the counter. The bench therefore writes new interval values only through the bus.

// File: rtl/mpwm_stat_pkg.sv
package mpwm_stat_pkg;

  localparam int NCH_DEF   = 6;
  localparam int CNT_W_DEF = 3;
  localparam int DW_DEF    = 16;
  localparam int AW_DEF    = 2;

  // Bit positions that software decodes
  localparam int POS_DIR   = 15;
  localparam int POS_CNT   = 12;
  localparam int POS_PRD   = 7;
  localparam int POS_BOT   = 6;
  localparam int NFLAG     = 8;

  // Control-register layout
  localparam int POS_IVL_EN  = 0;
  localparam int POS_IVL_VAL = 1;

  typedef enum logic [1:0] {
    ADR_STAT = 2'd0,
    ADR_EN   = 2'd1,
    ADR_CTRL = 2'd2,
    ADR_NONE = 2'd3
  } reg_adr_e;

  // Sticky flag update: hardware set has priority over software clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Per-channel source choice
  function automatic logic pick_src(input logic mode, input logic duty, input logic atr);
    return mode ? atr : duty;
  endfunction

  // Interval counter step on one period match
  function automatic logic [CNT_W_DEF-1:0] ivl_step(input logic [CNT_W_DEF-1:0] cnt,
                                                    input logic [CNT_W_DEF-1:0] lim);
    return (cnt == lim) ? '0 : cnt + 1'b1;
  endfunction

  // Assemble the status word from its fields
  function automatic logic [DW_DEF-1:0] pack_status(input logic dir,
                                                    input logic [CNT_W_DEF-1:0] cnt,
                                                    input logic [NFLAG-1:0] flags);
    logic [DW_DEF-1:0] w;
    w = '0;
    w[POS_DIR] = dir;
    w[POS_CNT +: CNT_W_DEF] = cnt;
    w[NFLAG-1:0] = flags;
    return w;
  endfunction

endpackage

// File: rtl/mpwm_flag_cell.sv
module mpwm_flag_cell
  import mpwm_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_next(flag_o, set_i, clr_i);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);  // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);  // R4
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> (flag_o == $past(flag_o)));  // R4

endmodule

// File: rtl/mpwm_chan_bank.sv
module mpwm_chan_bank
  import mpwm_stat_pkg::*;
#(
  parameter int NCH = NCH_DEF
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] duty_match,
  input  logic [NCH-1:0] atr_match,
  input  logic [NCH-1:0] atr_mode,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] flags
);

  logic [NCH-1:0] ch_set;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ch_set[k] = pick_src(atr_mode[k], duty_match[k], atr_match[k]);

    mpwm_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (ch_set[k]),
      .clr_i  (clr[k]),
      .flag_o (flags[k])
    );

    AST_SRC_GATE_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      (!atr_mode[k] && !duty_match[k] && !flags[k]) |=> !flags[k]);  // R6
    AST_SRC_GATE_ATR: assert property (@(posedge clk) disable iff (!rst_n)
      (atr_mode[k] && !atr_match[k] && !flags[k]) |=> !flags[k]);  // R6
  end

endmodule

// File: rtl/mpwm_period_unit.sv
module mpwm_period_unit
  import mpwm_stat_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prd_match,
  input  logic             bot_match,
  input  logic             ivl_en,
  input  logic [CNT_W-1:0] ivl_val,
  input  logic             ctrl_wr,
  input  logic             clr_prd,
  input  logic             clr_bot,
  output logic [CNT_W-1:0] cnt,
  output logic             prd_flag,
  output logic             bot_flag
);

  logic prd_hit;
  logic prd_set;

  assign prd_hit = prd_match && ivl_en && (cnt == ivl_val);
  assign prd_set = prd_match && (!ivl_en || (cnt == ivl_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (ctrl_wr || !ivl_en) cnt <= '0;
    else if (prd_match)        cnt <= ivl_step(cnt, ivl_val);
  end

  mpwm_flag_cell u_prd (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (prd_set),
    .clr_i  (clr_prd),
    .flag_o (prd_flag)
  );

  mpwm_flag_cell u_bot (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (bot_match),
    .clr_i  (clr_bot),
    .flag_o (bot_flag)
  );

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_en |-> (cnt <= ivl_val));  // R7
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    prd_hit |=> (cnt == '0 && prd_flag));  // R7
  AST_CTRL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cnt == '0));  // R9

endmodule

// File: rtl/mpwm_irq_status.sv
module mpwm_irq_status
  import mpwm_stat_pkg::*;
#(
  parameter int NCH   = NCH_DEF,
  parameter int CNT_W = CNT_W_DEF,
  parameter int DW    = DW_DEF,
  parameter int AW    = AW_DEF
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_down,
  input  logic           prd_match,
  input  logic           bot_match,
  input  logic [NCH-1:0] duty_match,
  input  logic [NCH-1:0] atr_match,
  input  logic [NCH-1:0] atr_mode,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           irq
);

  localparam int NF = NCH + 2;

  logic             wr_stat, wr_en, wr_ctrl;
  logic [NCH-1:0]   clr_ch;
  logic             clr_prd, clr_bot;
  logic [NCH-1:0]   ch_flags;
  logic             prd_flag, bot_flag;
  logic [CNT_W-1:0] ivl_cnt;
  logic [NF-1:0]    all_flags;
  logic [NF-1:0]    en_q;
  logic             ivl_en_q;
  logic [CNT_W-1:0] ivl_val_q;
  logic [DW-1:0]    stat_word, en_word, ctrl_word;
  logic [DW-1:0]    unused_wdata;

  assign wr_stat = bus_wr && (bus_addr == AW'(ADR_STAT));
  assign wr_en   = bus_wr && (bus_addr == AW'(ADR_EN));
  assign wr_ctrl = bus_wr && (bus_addr == AW'(ADR_CTRL));

  assign clr_ch  = wr_stat ? bus_wdata[NCH-1:0] : '0;
  assign clr_prd = wr_stat && bus_wdata[POS_PRD];
  assign clr_bot = wr_stat && bus_wdata[POS_BOT];

  assign unused_wdata = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      ivl_en_q  <= 1'b0;
      ivl_val_q <= '0;
    end else begin
      if (wr_en) en_q <= bus_wdata[NF-1:0];
      if (wr_ctrl) begin
        ivl_en_q  <= bus_wdata[POS_IVL_EN];
        ivl_val_q <= bus_wdata[POS_IVL_VAL +: CNT_W];
      end
    end
  end

  mpwm_chan_bank #(.NCH(NCH)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .duty_match (duty_match),
    .atr_match  (atr_match),
    .atr_mode   (atr_mode),
    .clr        (clr_ch),
    .flags      (ch_flags)
  );

  mpwm_period_unit #(.CNT_W(CNT_W)) u_prd (
    .clk       (clk),
    .rst_n     (rst_n),
    .prd_match (prd_match),
    .bot_match (bot_match),
    .ivl_en    (ivl_en_q),
    .ivl_val   (ivl_val_q),
    .ctrl_wr   (wr_ctrl),
    .clr_prd   (clr_prd),
    .clr_bot   (clr_bot),
    .cnt       (ivl_cnt),
    .prd_flag  (prd_flag),
    .bot_flag  (bot_flag)
  );

  assign all_flags = {prd_flag, bot_flag, ch_flags};
  assign stat_word = pack_status(cnt_down, ivl_cnt, all_flags);

  always_comb begin
    en_word = '0;
    en_word[NF-1:0] = en_q;
    ctrl_word = '0;
    ctrl_word[POS_IVL_EN] = ivl_en_q;
    ctrl_word[POS_IVL_VAL +: CNT_W] = ivl_val_q;
  end

  always_comb begin
    unique case (bus_addr)
      AW'(ADR_STAT): bus_rdata = stat_word;
      AW'(ADR_EN):   bus_rdata = en_word;
      AW'(ADR_CTRL): bus_rdata = ctrl_word;
      default:       bus_rdata = '0;
    endcase
  end

  assign irq = |(all_flags & en_q);

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);  // R8
  AST_DIR_BIT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !prd_match && !wr_ctrl) |=> (ivl_cnt == $past(ivl_cnt)));  // R2
  AST_FLAGS_CLEAN_AFTER_RST: assert property (@(posedge clk)
    $rose(rst_n) |-> (all_flags == '0 && en_q == '0));  // R1

endmodule

// File: tb/mpwm_irq_status_tb.sv
module mpwm_irq_status_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_down = 1'b0;
  logic        prd_match = 1'b0;
  logic        bot_match = 1'b0;
  logic [5:0]  duty_match = '0;
  logic [5:0]  atr_match = '0;
  logic [5:0]  atr_mode = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  always #4 clk = ~clk;  // 125 MHz

  mpwm_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_down(cnt_down),
    .prd_match(prd_match), .bot_match(bot_match),
    .duty_match(duty_match), .atr_match(atr_match), .atr_mode(atr_mode),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    string       tag;
    bit          is_irq;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (q.size() > 0);
      #1;
      begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {15'd0, irq} : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_reg(input logic [1:0] a, input logic [15:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.tag = tag; it.is_irq = 0; it.exp = e;
    q.push_back(it);
    #2;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    it.tag = tag; it.is_irq = 1; it.exp = {15'd0, e};
    q.push_back(it);
    #2;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic pulse(input logic p, input logic b, input logic [5:0] du, input logic [5:0] at);
    @(negedge clk);
    prd_match = p; bot_match = b; duty_match = du; atr_match = at;
    @(negedge clk);
    prd_match = 0; bot_match = 0; duty_match = '0; atr_match = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_reg(2'd0, 16'h0000, "R1 status");
    expect_reg(2'd1, 16'h0000, "R1 enable");
    expect_reg(2'd2, 16'h0000, "R1 control");
    expect_irq(1'b0, "R1 irq");

    // R2 direction bit, read-only fields
    cnt_down = 1; #1;
    expect_reg(2'd0, 16'h8000, "R2 dir down");
    bus_write(2'd0, 16'hFF00);
    expect_reg(2'd0, 16'h8000, "R2 ro write ignored");
    cnt_down = 0; #1;
    expect_reg(2'd0, 16'h0000, "R2 dir up");
    expect_reg(2'd3, 16'h0000, "R9 addr3 zero");

    // R3 period and bottom flags
    pulse(1, 0, 6'h00, 6'h00);
    expect_reg(2'd0, 16'h0080, "R3 period flag");
    pulse(0, 1, 6'h00, 6'h00);
    expect_reg(2'd0, 16'h00C0, "R3 bottom flag");

    // R4 write-one-to-clear
    bus_write(2'd0, 16'h0040);
    expect_reg(2'd0, 16'h0080, "R4 clear bottom");
    bus_write(2'd0, 16'h0000);
    expect_reg(2'd0, 16'h0080, "R4 zero write keeps");
    bus_write(2'd0, 16'h0080);
    expect_reg(2'd0, 16'h0000, "R4 clear period");

    // R6 source selection
    pulse(0, 0, 6'h00, 6'h3F);
    expect_reg(2'd0, 16'h0000, "R6 atr ignored in duty mode");
    pulse(0, 0, 6'h15, 6'h00);
    expect_reg(2'd0, 16'h0015, "R6 duty sets");
    atr_mode = 6'h3F;
    pulse(0, 0, 6'h2A, 6'h00);
    expect_reg(2'd0, 16'h0015, "R6 duty ignored in atr mode");
    pulse(0, 0, 6'h00, 6'h2A);
    expect_reg(2'd0, 16'h003F, "R6 atr sets");
    bus_write(2'd0, 16'h003F);
    expect_reg(2'd0, 16'h0000, "R4 clear channel flags");

    // R5 set beats clear in the same cycle
    @(negedge clk);
    atr_match = 6'h01; bot_match = 1;
    bus_wr = 1; bus_addr = 2'd0; bus_wdata = 16'h0041;
    @(negedge clk);
    atr_match = '0; bot_match = 0; bus_wr = 0;
    expect_reg(2'd0, 16'h0041, "R5 set wins");

    // R8 interrupt masking
    expect_irq(1'b0, "R8 no enable");
    bus_write(2'd1, 16'h0001);
    expect_irq(1'b1, "R8 chan enable");
    expect_reg(2'd1, 16'h0001, "R8 enable readback");
    bus_write(2'd1, 16'hFF40);
    expect_reg(2'd1, 16'h0040, "R8 upper enable bits zero");
    expect_irq(1'b1, "R8 bottom enable");
    bus_write(2'd0, 16'h0040);
    expect_irq(1'b0, "R8 flag cleared drops irq");
    bus_write(2'd0, 16'h0001);
    expect_reg(2'd0, 16'h0000, "R4 all clear");

    // R9 / R7 interval mode, V = 2
    bus_write(2'd2, 16'h0005);
    expect_reg(2'd2, 16'h0005, "R9 control readback");
    pulse(1, 0, 6'h00, 6'h00);
    expect_reg(2'd0, 16'h1000, "R7 count 1");
    pulse(1, 0, 6'h00, 6'h00);
    expect_reg(2'd0, 16'h2000, "R7 count 2");
    pulse(1, 0, 6'h00, 6'h00);
    expect_reg(2'd0, 16'h0080, "R7 flag and wrap");
    pulse(1, 0, 6'h00, 6'h00);
    expect_reg(2'd0, 16'h1080, "R7 restart count");
    bus_write(2'd2, 16'h0005);
    expect_reg(2'd0, 16'h0080, "R9 control write resets counter");

    #10;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule